// File: doc/BRIEF.md
# Large-Page NAND Command Sequencer

This block turns one request into the exact command and address bus cycles that a large-page parallel NAND flash expects. A request carries an opcode, a column address with a valid flag, a page address with a valid flag, and the device configuration: page data size, bus width, whether the device is above 128 MiB, whether a ready/busy line is wired, and a chip delay in microseconds. The sequencer drives chip enable, the command and address latch enables, the write and read strobes and the 8-bit I/O bus. Once the addresses are out, it handles whatever the opcode needs next.

Each opcode has its own ending. A page read gets a start-confirm command and then a wait. A random data-out gets its confirm byte and ends at once. Program, erase, data-in and status opcodes end with no wait. A reset on a board with no ready/busy line waits the chip delay and then polls the status byte. An out-of-band read becomes a normal read whose column is moved past the page data. The handshake is a single-cycle `req` pulse, with `busy` high while the sequence runs and a one-cycle `done` pulse at the end.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the outputs are ce_n=1, cle=0, ale=0, we_n=1, re_n=1, io_oe=0, io_out=0, busy=0 and done=0.
- R2: A `req` seen while `busy` is low is accepted, and the opcode cycle appears in the next clock. A `req` seen while `busy` is high is ignored. The last cycle of every sequence has done=1 with ce_n=1, and the block is idle (busy=0) in the cycle after it.
- R3: Each command or address byte takes two clocks: we_n low and then we_n high, with io_oe=1 and the byte held on io_out for both clocks. Commands drive cle=1, addresses drive ale=1, and ce_n stays 0 from the opcode cycle to the cycle before done. cle and ale are never high together.
- R4: When the column is valid it goes out as two address bytes, bits 7:0 first and then bits 15:8. With bus16=1 the column is shifted right by one bit before it is sent.
- R5: When the page is valid it goes out as bits 7:0 and then bits 15:8. A third byte with bits 23:16 follows only when big_dev=1.
- R6: After the last address byte there is exactly one gap cycle with ce_n=0, cle=0, ale=0, we_n=1 and io_oe=0.
- R7: Opcode 0x50 (out-of-band read) is sent as opcode 0x00. Its column is the requested column plus page_bytes, and this sum is taken before the bus16 shift.
- R8: For opcode 0x00, the gap is followed by the confirm command 0x30, one more gap cycle and then the wait policy of R11.
- R9: For opcode 0x05 (random data out), the gap is followed by the confirm command 0xE0 and one gap cycle, and then done comes with no wait and with rb ignored.
- R10: Opcodes 0x10, 0x15, 0x60, 0xD0, 0x80, 0x85 and 0x70 reach done in the clock right after the gap cycle, with no delay.
- R11: For every other opcode, and for reset when has_rb=1, the block holds an idle-bus wait state with ce_n=0. With has_rb=1 this lasts ceil(100 ns / clock period) clocks (25 at 4 ns) and then continues until rb is sampled high. With has_rb=0 it lasts chip_dly_us × (1 µs / clock period) clocks, at least one clock, followed by done.
- R12: For opcode 0xFF with has_rb=0, the gap is followed by the chip-delay wait, then status command 0x70, one gap cycle, and then status polls. Each poll is one clock with re_n=0 and io_oe=0, sampling io_in, followed by one clock with re_n=1. Polling repeats until a sampled io_in has bit 6 set (mask 0x40), and the other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken only while idle |
| opcode | input | 8 | Requested command opcode |
| col_valid | input | 1 | Column address present |
| col_addr | input | 16 | Column address in bytes |
| page_valid | input | 1 | Page address present |
| page_addr | input | 24 | Page (row) address |
| page_bytes | input | 16 | Page data size in bytes |
| bus16 | input | 1 | Device bus is 16 bits wide |
| big_dev | input | 1 | Device is larger than 128 MiB |
| has_rb | input | 1 | Ready/busy line is available |
| chip_dly_us | input | 8 | Chip delay in microseconds |
| rb | input | 1 | Ready/busy line, high when ready |
| io_in | input | 8 | I/O bus read value, status byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_oe | output | 1 | I/O bus output enable |
| io_out | output | 8 | I/O bus drive value |

## Verification
The assertions assume that `req` is a single-clock pulse and that the request fields are valid in the clock where `req` is accepted. They also assume that `rb` and `io_in` only change away from the clock edge. The bench drives every input on the falling edge, and it releases `req` in the first clock of the sequence except for one deliberate pulse during `busy`. It raises `rb` or the status ready bit only at cycle indices that its own model has worked out, which keeps the wait and poll exits deterministic. The not-ready status value has every bit except bit 6 set, so a wrong mask shows up.

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq #(
  parameter int CLK_PS = 4000,
  parameter int TWB_PS = 100000,
  parameter int US_PS  = 1000000,
  parameter int DLY_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [7:0]  opcode,
  input  logic        col_valid,
  input  logic [15:0] col_addr,
  input  logic        page_valid,
  input  logic [23:0] page_addr,
  input  logic [15:0] page_bytes,
  input  logic        bus16,
  input  logic        big_dev,
  input  logic        has_rb,
  input  logic [7:0]  chip_dly_us,
  input  logic        rb,
  input  logic [7:0]  io_in,
  output logic        busy,
  output logic        done,
  output logic        ce_n,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic        io_oe,
  output logic [7:0]  io_out
);
  localparam int TWB_CYC = (TWB_PS + CLK_PS - 1) / CLK_PS;
  localparam int US_CYC  = US_PS / CLK_PS;
  localparam logic [7:0] OP_READ = 8'h00, OP_OOB = 8'h50, OP_RNDOUT = 8'h05;
  localparam logic [7:0] OP_RESET = 8'hFF, OP_STATUS = 8'h70;
  localparam logic [7:0] CF_READ = 8'h30, CF_RNDOUT = 8'hE0;
  localparam logic [7:0] READY_MASK = 8'h40;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_C0, S_C1, S_R0, S_R1, S_R2, S_GAP, S_SCMD, S_DLY, S_WRB, S_RD, S_DONE
  } st_t;
  typedef enum logic [2:0] {G_ADDR, G_CONF, G_RSTDLY, G_STAT, G_FIN} stage_t;

  st_t              st, nxt_wr;
  stage_t           stage;
  logic             ph, colv_q, pgv_q, big_q, hrb_q, rdy_q, wr_st;
  logic [7:0]       op_q, cbyte, dly_q;
  logic [15:0]      col_q, col_sum;
  logic [23:0]      page_q;
  logic [DLY_W-1:0] cnt, chip_cyc, fin_cyc;

  function automatic logic [DLY_W-1:0] ld(input logic [DLY_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic no_wait(input logic [7:0] o);
    return o inside {8'h10, 8'h15, 8'h60, 8'hD0, 8'h80, 8'h85, OP_STATUS};
  endfunction

  assign col_sum  = col_addr + ((opcode == OP_OOB) ? page_bytes : 16'h0);
  assign chip_cyc = DLY_W'(dly_q) * DLY_W'(US_CYC);
  assign fin_cyc  = hrb_q ? DLY_W'(TWB_CYC) : chip_cyc;
  assign wr_st    = st inside {S_CMD, S_C0, S_C1, S_R0, S_R1, S_R2, S_SCMD};

  assign busy  = st != S_IDLE;
  assign done  = st == S_DONE;
  assign ce_n  = st == S_IDLE || st == S_DONE;
  assign cle   = st == S_CMD || st == S_SCMD;
  assign ale   = st inside {S_C0, S_C1, S_R0, S_R1, S_R2};
  assign we_n  = !(wr_st && !ph);
  assign re_n  = !(st == S_RD && !ph);
  assign io_oe = wr_st;

  always_comb begin
    case (st)
      S_CMD:   io_out = op_q;
      S_C0:    io_out = col_q[7:0];
      S_C1:    io_out = col_q[15:8];
      S_R0:    io_out = page_q[7:0];
      S_R1:    io_out = page_q[15:8];
      S_R2:    io_out = page_q[23:16];
      S_SCMD:  io_out = cbyte;
      default: io_out = 8'h00;
    endcase
  end

  always_comb begin
    case (st)
      S_CMD:   nxt_wr = colv_q ? S_C0 : (pgv_q ? S_R0 : S_GAP);
      S_C0:    nxt_wr = S_C1;
      S_C1:    nxt_wr = pgv_q ? S_R0 : S_GAP;
      S_R0:    nxt_wr = S_R1;
      S_R1:    nxt_wr = big_q ? S_R2 : S_GAP;
      default: nxt_wr = S_GAP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; stage <= G_ADDR; ph <= 1'b0;
      op_q <= '0; col_q <= '0; colv_q <= 1'b0; page_q <= '0; pgv_q <= 1'b0;
      big_q <= 1'b0; hrb_q <= 1'b0; dly_q <= '0; cbyte <= '0; cnt <= '0; rdy_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          op_q   <= (opcode == OP_OOB) ? OP_READ : opcode;
          col_q  <= bus16 ? {1'b0, col_sum[15:1]} : col_sum;
          colv_q <= col_valid;
          page_q <= page_addr;
          pgv_q  <= page_valid;
          big_q  <= big_dev;
          hrb_q  <= has_rb;
          dly_q  <= chip_dly_us;
          stage  <= G_ADDR;
          ph     <= 1'b0;
          st     <= S_CMD;
        end
        S_CMD, S_C0, S_C1, S_R0, S_R1, S_R2, S_SCMD: begin
          ph <= !ph;
          if (ph) st <= nxt_wr;
        end
        S_GAP: case (stage)
          G_ADDR:
            if (no_wait(op_q)) st <= S_DONE;
            else if (op_q == OP_READ) begin
              cbyte <= CF_READ; stage <= G_CONF; st <= S_SCMD;
            end else if (op_q == OP_RNDOUT) begin
              cbyte <= CF_RNDOUT; stage <= G_CONF; st <= S_SCMD;
            end else if (op_q == OP_RESET && !hrb_q) begin
              cnt <= ld(chip_cyc); stage <= G_RSTDLY; st <= S_DLY;
            end else begin
              cnt <= ld(fin_cyc); stage <= G_FIN; st <= S_DLY;
            end
          G_CONF:
            if (op_q == OP_RNDOUT) st <= S_DONE;
            else begin
              cnt <= ld(fin_cyc); stage <= G_FIN; st <= S_DLY;
            end
          G_STAT: st <= S_RD;
          default: st <= S_DONE;
        endcase
        S_DLY:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (stage == G_RSTDLY) begin
            cbyte <= OP_STATUS; stage <= G_STAT; st <= S_SCMD;
          end else st <= hrb_q ? S_WRB : S_DONE;
        S_WRB: if (rb) st <= S_DONE;
        S_RD: begin
          ph <= !ph;
          if (!ph) rdy_q <= (io_in & READY_MASK) != 8'h00;
          else if (rdy_q) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  no_cle_ale_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));
  // R3
  strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || cle || ale) |-> !ce_n);
  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> (we_n && io_oe && $stable(io_out)));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> (busy && cle && !we_n));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  // R12
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> (!io_oe && !cle && !ale && !ce_n));
  // R11
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRB && !rb) |=> (busy && !done && ce_n == 1'b0));
endmodule

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, col_valid = 1'b0, page_valid = 1'b0, bus16 = 1'b0, big_dev = 1'b0;
  logic has_rb = 1'b0, rb = 1'b0;
  logic [7:0] opcode = 8'h00, chip_dly_us = 8'h00, io_in = 8'h00;
  logic [15:0] col_addr = 16'h0, page_bytes = 16'd2048;
  logic [23:0] page_addr = 24'h0;
  logic busy, done, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] io_out;
  int checks = 0, fails = 0;
  logic [15:0] exq[$];
  int rb_idx, rdy_idx;
  localparam int TWB = 25;
  localparam int USC = 250;

  always #2 clk = ~clk;

  nand_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode), .col_valid(col_valid),
    .col_addr(col_addr), .page_valid(page_valid), .page_addr(page_addr),
    .page_bytes(page_bytes), .bus16(bus16), .big_dev(big_dev), .has_rb(has_rb),
    .chip_dly_us(chip_dly_us), .rb(rb), .io_in(io_in), .busy(busy), .done(done),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_oe(io_oe),
    .io_out(io_out));

  function automatic logic [15:0] pk(logic c, logic l, logic a, logic w, logic r,
                                     logic o, logic d, logic b, logic [7:0] v);
    return {c, l, a, w, r, o, d, b, v};
  endfunction

  task automatic put_wr(logic is_cmd, logic [7:0] v);
    exq.push_back(pk(0, is_cmd, !is_cmd, 0, 1, 1, 0, 1, v));
    exq.push_back(pk(0, is_cmd, !is_cmd, 1, 1, 1, 0, 1, v));
  endtask
  task automatic put_quiet(int n);
    for (int k = 0; k < n; k++) exq.push_back(pk(0, 0, 0, 1, 1, 0, 0, 1, 8'h00));
  endtask

  function automatic logic [15:0] got();
    return {ce_n, cle, ale, we_n, re_n, io_oe, done, busy, io_out};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic [7:0] op, logic cv, logic [15:0] ca, logic pv,
                     logic [23:0] pa, logic b16, logic big, logic hrb, logic [7:0] dus,
                     int wrb, int npoll, logic noise);
    logic [7:0] eop;
    logic [15:0] ec;
    int cdly;
    exq.delete();
    rb_idx = 0; rdy_idx = 1 << 30;
    eop = (op == 8'h50) ? 8'h00 : op;
    ec = ca + ((op == 8'h50) ? page_bytes : 16'h0);
    if (b16) ec = ec >> 1;
    cdly = int'(dus) * USC;
    if (cdly < 1) cdly = 1;
    put_wr(1, eop);
    if (cv) begin put_wr(0, ec[7:0]); put_wr(0, ec[15:8]); end
    if (pv) begin
      put_wr(0, pa[7:0]); put_wr(0, pa[15:8]);
      if (big) put_wr(0, pa[23:16]);
    end
    put_quiet(1);
    if (eop inside {8'h10, 8'h15, 8'h60, 8'hD0, 8'h80, 8'h85, 8'h70}) begin
    end else if (eop == 8'h05) begin
      put_wr(1, 8'hE0); put_quiet(1);
    end else if (eop == 8'hFF && !hrb) begin
      put_quiet(cdly); put_wr(1, 8'h70); put_quiet(1);
      rdy_idx = exq.size() + 2 * npoll;
      for (int k = 0; k <= npoll; k++) begin
        exq.push_back(pk(0, 0, 0, 1, 0, 0, 0, 1, 8'h00));
        exq.push_back(pk(0, 0, 0, 1, 1, 0, 0, 1, 8'h00));
      end
    end else begin
      if (eop == 8'h00) begin put_wr(1, 8'h30); put_quiet(1); end
      if (hrb) begin
        put_quiet(TWB);
        rb_idx = exq.size() + wrb - 1;
        put_quiet(wrb);
      end else put_quiet(cdly);
    end
    exq.push_back(pk(1, 0, 0, 1, 1, 0, 1, 1, 8'h00));
    for (int k = 0; k < 3; k++) exq.push_back(pk(1, 0, 0, 1, 1, 0, 0, 0, 8'h00));

    @(negedge clk);
    opcode = op; col_valid = cv; col_addr = ca; page_valid = pv; page_addr = pa;
    bus16 = b16; big_dev = big; has_rb = hrb; chip_dly_us = dus;
    rb = hrb ? 1'b0 : 1'b1; io_in = 8'hBF; req = 1'b1;
    for (int i = 0; i < exq.size(); i++) begin
      @(negedge clk);
      check(tag, got(), exq[i]);
      req = noise && (i == 2);
      if (i == 0) begin opcode = 8'hA5; col_addr = 16'hFFFF; page_addr = 24'hFFFFFF; end
      if (noise && i == 2) opcode = 8'h00;
      if (hrb && i >= rb_idx) rb = 1'b1;
      io_in = (i >= rdy_idx) ? 8'h40 : 8'hBF;
    end
    rb = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", got(), pk(1, 0, 0, 1, 1, 0, 0, 0, 8'h00));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", got(), pk(1, 0, 0, 1, 1, 0, 0, 0, 8'h00));
    // R8 read with rb, R5 two page bytes, R4 column order, R6 gap
    run("R8", 8'h00, 1, 16'h0123, 1, 24'h0A4567, 0, 0, 1, 8'd1, 5, 0, 0);
    // R5 third page byte
    run("R5", 8'h00, 1, 16'h0010, 1, 24'hC34567, 0, 1, 1, 8'd1, 1, 0, 0);
    // R7 out-of-band read, 8-bit and 16-bit bus (R4 shift after the sum)
    run("R7", 8'h50, 1, 16'h0010, 1, 24'h000100, 0, 0, 1, 8'd1, 3, 0, 0);
    run("R4", 8'h50, 1, 16'h0011, 1, 24'h000100, 1, 0, 1, 8'd1, 2, 0, 0);
    // R9 random data out, rb stays low and is ignored
    run("R9", 8'h05, 1, 16'h0200, 0, 24'h0, 0, 0, 1, 8'd1, 1, 0, 0);
    // R10 no-wait opcodes
    run("R10", 8'h80, 1, 16'h0040, 1, 24'h123456, 0, 1, 1, 8'd1, 1, 0, 0);
    run("R10", 8'h60, 0, 16'h0, 1, 24'h003300, 0, 0, 1, 8'd1, 1, 0, 0);
    run("R10", 8'h70, 0, 16'h0, 0, 24'h0, 0, 0, 1, 8'd1, 1, 0, 0);
    run("R10", 8'hD0, 0, 16'h0, 0, 24'h0, 0, 0, 0, 8'd1, 1, 0, 0);
    run("R10", 8'h10, 0, 16'h0, 0, 24'h0, 0, 0, 1, 8'd1, 1, 0, 0);
    run("R10", 8'h15, 0, 16'h0, 0, 24'h0, 0, 0, 1, 8'd1, 1, 0, 0);
    run("R10", 8'h85, 1, 16'h0321, 0, 24'h0, 0, 0, 1, 8'd1, 1, 0, 0);
    // R11 default opcode, chip delay and rb wait, zero delay clamps to one clock
    run("R11", 8'h90, 1, 16'h0000, 0, 24'h0, 0, 0, 0, 8'd1, 1, 0, 0);
    run("R11", 8'h00, 1, 16'h0004, 1, 24'h000077, 0, 0, 0, 8'd0, 1, 0, 0);
    run("R11", 8'hFF, 0, 16'h0, 0, 24'h0, 0, 0, 1, 8'd2, 7, 0, 0);
    // R12 reset polling, R2 request during busy ignored
    run("R12", 8'hFF, 0, 16'h0, 0, 24'h0, 0, 0, 0, 8'd1, 1, 3, 0);
    run("R12", 8'hFF, 0, 16'h0, 0, 24'h0, 0, 0, 0, 8'd2, 1, 0, 0);
    run("R2", 8'h60, 0, 16'h0, 1, 24'h000200, 0, 0, 1, 8'd1, 1, 0, 1);
    run("R3", 8'h00, 1, 16'hBEEF, 1, 24'hABCDEF, 0, 1, 1, 8'd1, 2, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule